// File: doc/BRIEF.md
# Pilot Block Position Indicator

This block sits after frame synchronization in a satellite receiver. It watches the stream of valid symbols that follows each frame header and flags the symbols that belong to pilot blocks. In a frame that carries pilots, each run of 1440 data symbols is followed by 36 pilot symbols. This pattern repeats until the header of the next frame is detected.

Two inputs mark frame boundaries. One is a one-cycle start-of-frame pulse, raised on the cycle that carries the last header symbol. The other is a pilots-present flag, which is sampled on that same cycle. A later pulse restarts the count at once. Any pilot block that was due at that point, or already under way, is cancelled. This is how the block finds the end of a frame without knowing the frame's length.

Alongside the flag, the block gives each pilot symbol its position (0 to 35) inside its block. Downstream phase, gain and noise estimators use the flag and the position to select the matching reference symbols.

Top module: `pilot_locator`

## Requirements
- R1: After a synchronous reset, and until the first start-of-frame pulse, `pilot_valid` is 0 and `pilot_idx` is 0.
- R2: `pilot_valid` is raised only in frames whose `pilots_in` was 1 on the cycle of that frame's start-of-frame pulse.
- R3: The first 1440 valid symbols after a start-of-frame pulse are data symbols, and `pilot_valid` is 0 for them. The symbol on the pulse cycle itself is not counted.
- R4: The 36 valid symbols that follow the data run have `pilot_valid` = 1. Their `pilot_idx` values are 0, 1, ... 35, in order.
- R5: After each pilot block the count restarts. Another 1440 data symbols and 36 pilot symbols follow, and so on, with no limit on the number of blocks.
- R6: Cycles with `sym_valid` = 0 do not advance the count. On those cycles `pilot_valid` is 0.
- R7: A start-of-frame pulse restarts the count on any cycle, even inside a pilot block. On the pulse cycle, `pilot_valid` is 0.
- R8: Changes of `pilots_in` between start-of-frame pulses have no effect.
- R9: `pilot_idx` is 0 on every cycle on which `pilot_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A symbol is present this cycle |
| sof | input | 1 | One-cycle pulse on the last header symbol of a frame |
| pilots_in | input | 1 | Frame carries pilots; sampled when `sof` is 1 |
| pilot_valid | output | 1 | The current symbol is a pilot (combinational on the inputs) |
| pilot_idx | output | 6 | Position of the symbol in its pilot block, 0 outside blocks |

## Verification
Several properties are checked on every cycle:
- the flag stays silent before the first frame, on idle cycles and on header-end cycles;
- the flag is never raised in a frame without pilots;
- the position is zero outside blocks and stays in range;
- inside a block, the positions follow each other without gaps across idle cycles.

Some behaviour needs a counted history and is shown only by the bench scenarios. This covers the exact 1440-symbol data run, the repetition over several blocks, cancellation when a new header lands at the start of a pilot block or in its middle, and toggling of the pilots flag in mid-frame.

// File: rtl/pilot_locator.sv
module pilot_locator #(
  parameter int DATA_LEN  = 1440,
  parameter int PILOT_LEN = 36
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_valid,
  input  logic       sof,
  input  logic       pilots_in,
  output logic       pilot_valid,
  output logic [5:0] pilot_idx
);
  localparam int CW = $clog2((DATA_LEN > PILOT_LEN) ? DATA_LEN : PILOT_LEN);

  logic [CW-1:0] cnt;
  logic          in_pilot;
  logic          active;
  logic          has_pilots;

  wire data_end  = !in_pilot && (cnt == CW'(DATA_LEN - 1));
  wire pilot_end =  in_pilot && (cnt == CW'(PILOT_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      in_pilot   <= 1'b0;
      active     <= 1'b0;
      has_pilots <= 1'b0;
    end else if (sof) begin
      cnt        <= '0;
      in_pilot   <= 1'b0;
      active     <= 1'b1;
      has_pilots <= pilots_in;
    end else if (sym_valid && active) begin
      if (data_end || pilot_end) begin
        cnt      <= '0;
        in_pilot <= !in_pilot;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pilot_valid = sym_valid && !sof && active && has_pilots && in_pilot;
  assign pilot_idx   = pilot_valid ? 6'(cnt) : 6'd0;
endmodule

// File: rtl/pilot_locator_chk.sv
module pilot_locator_chk #(
  parameter int PILOT_LEN = 36
) (
  input logic       clk,
  input logic       rst,
  input logic       sym_valid,
  input logic       sof,
  input logic       pilots_in,
  input logic       pilot_valid,
  input logic [5:0] pilot_idx
);
  logic       seen_sof;
  logic       pil_l;
  logic       armed;
  logic [5:0] exp_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_sof <= 1'b0;
      pil_l    <= 1'b0;
      armed    <= 1'b0;
      exp_next <= '0;
    end else begin
      if (sof) begin
        seen_sof <= 1'b1;
        pil_l    <= pilots_in;
      end
      if (sof) armed <= 1'b0;
      else if (pilot_valid) begin
        armed    <= (pilot_idx != 6'(PILOT_LEN - 1));
        exp_next <= pilot_idx + 6'd1;
      end else if (sym_valid) armed <= 1'b0;
    end
  end

  assert_quiet_before_frame_R1: assert property (@(posedge clk) disable iff (rst)
    !seen_sof |-> (!pilot_valid && pilot_idx == 6'd0));
  assert_no_flag_without_pilots_R2: assert property (@(posedge clk) disable iff (rst)
    (!sof && !pil_l) |-> !pilot_valid);
  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    pilot_valid |-> (pilot_idx < 6'(PILOT_LEN)));
  assert_idx_step_R4: assert property (@(posedge clk) disable iff (rst)
    (pilot_valid && pilot_idx != 6'd0) |-> (armed && pilot_idx == exp_next));
  assert_idle_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |-> !pilot_valid);
  assert_sof_cancels_R7: assert property (@(posedge clk) disable iff (rst)
    sof |-> !pilot_valid);
  assert_idx_zero_outside_R9: assert property (@(posedge clk) disable iff (rst)
    !pilot_valid |-> (pilot_idx == 6'd0));
endmodule

bind pilot_locator pilot_locator_chk #(.PILOT_LEN(PILOT_LEN)) u_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sof(sof), .pilots_in(pilots_in),
  .pilot_valid(pilot_valid), .pilot_idx(pilot_idx)
);

// File: tb/tb_pilot_locator.sv
module tb_pilot_locator;
  localparam int DL = 1440;
  localparam int PL = 36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0;
  logic sof = 1'b0;
  logic pilots_in = 1'b0;
  logic       pilot_valid;
  logic [5:0] pilot_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit m_started = 0;
  bit m_pil = 0;
  int m_n = 0;

  always #4 clk = ~clk;

  pilot_locator dut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sof(sof), .pilots_in(pilots_in),
    .pilot_valid(pilot_valid), .pilot_idx(pilot_idx)
  );

  function automatic bit exp_pv(bit r, bit v, bit s);
    if (r || !v || s || !m_started || !m_pil) return 0;
    return (m_n % (DL + PL)) >= DL;
  endfunction

  function automatic int exp_idx(bit pv);
    return pv ? (m_n % (DL + PL)) - DL : 0;
  endfunction

  task automatic step(bit r, bit v, bit s, bit p, string tag);
    bit pv;
    int ix;
    @(negedge clk);
    rst = r; sym_valid = v; sof = s; pilots_in = p;
    #2;
    pv = exp_pv(r, v, s);
    ix = exp_idx(pv);
    total++;
    if (pilot_valid !== pv) begin
      bad++;
      $display("FAIL %s pilot_valid actual=%0b expected=%0b", tag, pilot_valid, pv);
    end
    total++;
    if (pilot_idx !== 6'(ix)) begin
      bad++;
      $display("FAIL %s pilot_idx actual=%0d expected=%0d", pv ? tag : "R9", pilot_idx, ix);
    end
    if (r) begin m_started = 0; m_pil = 0; m_n = 0; end
    else if (s) begin m_started = 1; m_pil = p; m_n = 0; end
    else if (v) m_n++;
  endtask

  task automatic run(int n, int vpct, bit p, bit toggle, string tag);
    for (int i = 0; i < n; i++)
      step(0, ($urandom % 100) < vpct, 0, toggle ? 1'($urandom) : p, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1776));
    for (int i = 0; i < 4; i++) step(1, 1'($urandom), 0, 1, "R1");
    for (int i = 0; i < 50; i++) step(0, 1'($urandom), 0, 1'($urandom), "R1");
    // pilot frame, continuous valid, several blocks (R3, R4, R5)
    step(0, 1, 1, 1, "R7");
    run(DL, 100, 1, 0, "R3");
    run(PL, 100, 1, 0, "R4");
    run(3 * (DL + PL), 100, 1, 0, "R5");
    // gaps in valid, pilots_in toggling mid-frame (R6, R8)
    step(0, 1, 1, 1, "R7");
    run(2 * (DL + PL) + 400, 60, 0, 1, "R6");
    run(DL + PL, 90, 0, 1, "R8");
    // frame without pilots, pilots_in raised afterwards (R2, R8)
    step(0, 0, 1, 0, "R2");
    run(2 * (DL + PL), 85, 1, 0, "R2");
    // new header inside a pilot block (R7)
    step(0, 1, 1, 1, "R7");
    run(DL + 10, 100, 1, 0, "R4");
    step(0, 1, 1, 1, "R7");
    // new header exactly when a block is due (R7)
    run(DL, 100, 0, 0, "R3");
    step(0, 1, 1, 1, "R7");
    run(DL + PL + 5, 100, 1, 0, "R4");
    // reset in mid-frame (R1)
    step(1, 1, 0, 1, "R1");
    run(DL + PL + 5, 100, 1, 0, "R1");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule